// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block predicts the direction of conditional branches. It is a direct-mapped table of small saturating state machines, one per entry, selected by the low word-address bits of the branch address. The fetch stage presents a branch address and its target. In the same cycle the block returns a direction guess and the address to fetch next: the target when the guess is taken, or the branch address plus four when it is not. There are no tags and no stored targets, so branches whose low address bits match share one entry.

When a branch completes, the execute stage presents its address, its target and the real direction, with a valid strobe. The block compares the real direction with the entry's current guess and raises a mispredict flag if they differ. It also gives the correct next address, and at the clock edge it moves the entry one step toward the real direction.

Each entry runs a four-state machine. The states are `ST_STRONG_T` (code 00) and `ST_WEAK_T` (01), which guess taken, and `ST_WEAK_N` (10) and `ST_STRONG_N` (11), which guess not taken. There are six step transitions: a taken outcome moves 11→10, 10→01 and 01→00, and a not-taken outcome moves 00→01, 01→10 and 10→11. There are two saturating holds: 00 stays at 00 on a taken outcome, and 11 stays at 11 on a not-taken outcome. Every entry starts in `ST_WEAK_N`.

Top module: `bht_predictor`

## Requirements
- R1: The table has 64 entries, and address bits [7:2] select the entry. Addresses that differ only outside bits [7:2] reach the same entry. An update to one entry leaves every other entry unchanged.
- R2: After reset, every entry is in state 10, so every lookup guesses not taken.
- R3: An entry in state 00 or 01 drives `pred_taken` to 1. An entry in state 10 or 11 drives it to 0.
- R4: On a valid resolve with a taken outcome, the entry's code decreases by one at the clock edge. An entry at 00 stays at 00.
- R5: On a valid resolve with a not-taken outcome, the entry's code increases by one at the clock edge. An entry at 11 stays at 11.
- R6: `pred_next_pc` equals `lk_target` when `pred_taken` is 1, and `lk_pc + 4` when it is 0.
- R7: `mispredict` is 1 only when `res_valid` is 1 and the entry's guess before the update differs from `res_taken`.
- R8: `recov_pc` equals `res_target` when `res_taken` is 1, and `res_pc + 4` when it is 0.
- R9: When `res_valid` is 0, no entry changes, whatever `res_pc` and `res_taken` hold.
- R10: When a lookup and a resolve select the same entry in one cycle, the lookup returns the guess from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_target | input | 32 | Target of the branch being looked up |
| pred_taken | output | 1 | Direction guess, 1 = taken |
| pred_next_pc | output | 32 | Address to fetch next |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_target | input | 32 | Target of the resolving branch |
| res_taken | input | 1 | Real direction of the resolving branch |
| mispredict | output | 1 | The guess for the resolving branch was wrong |
| recov_pc | output | 32 | Correct next address after the resolving branch |

## Verification
The checker tests these rules on every cycle:
- the next-address selection on both sides of the block;
- no mispredict without a valid resolve;
- the one-step move of the selected entry on a taken or a not-taken outcome;
- the frozen table when no resolve is valid.

Other behaviour needs the bench's scenarios:
- the reset pattern;
- aliasing through the upper address bits;
- saturation held over long runs of one outcome;
- a lookup that reads the pre-update value when it collides with a resolve on the same entry.

The bench sweeps all 64 entries with outcome sequences that differ from entry to entry. It keeps its own table, built from the rules above, and compares against it.

// File: rtl/bht_pkg.sv
package bht_pkg;
    typedef enum logic [1:0] {
        ST_STRONG_T = 2'b00,
        ST_WEAK_T   = 2'b01,
        ST_WEAK_N   = 2'b10,
        ST_STRONG_N = 2'b11
    } hist_t;

    localparam hist_t RESET_STATE = ST_WEAK_N;

    function automatic logic guess_taken(input hist_t s);
        return (s == ST_STRONG_T) || (s == ST_WEAK_T);
    endfunction
endpackage

// File: rtl/bht_entry.sv
module bht_entry
    import bht_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd_en,
    input  logic  taken,
    output hist_t state
);
    hist_t state_q;
    hist_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            unique case (state_q)
                ST_STRONG_T: state_d = taken ? ST_STRONG_T : ST_WEAK_T;
                ST_WEAK_T:   state_d = taken ? ST_STRONG_T : ST_WEAK_N;
                ST_WEAK_N:   state_d = taken ? ST_WEAK_T   : ST_STRONG_N;
                ST_STRONG_N: state_d = taken ? ST_WEAK_N   : ST_STRONG_N;
                default:     state_d = RESET_STATE;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/bht_lookup.sv
module bht_lookup
    import bht_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  hist_t [ENTRIES-1:0] tbl,
    input  logic  [IDX_W-1:0]   idx,
    input  logic  [PC_W-1:0]    pc,
    input  logic  [PC_W-1:0]    target,
    output logic                taken,
    output logic  [PC_W-1:0]    next_pc
);
    always_comb begin
        taken   = guess_taken(tbl[idx]);
        next_pc = taken ? target : pc + PC_W'(4);
    end
endmodule

// File: rtl/bht_resolve.sv
module bht_resolve
    import bht_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  hist_t            cur,
    input  logic             valid,
    input  logic             taken,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  target,
    output logic             mispredict,
    output logic [PC_W-1:0]  recov_pc
);
    always_comb begin
        mispredict = valid && (guess_taken(cur) != taken);
        recov_pc   = taken ? target : pc + PC_W'(4);
    end
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic [PC_W-1:0] lk_target,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_taken,
    output logic            mispredict,
    output logic [PC_W-1:0] recov_pc
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    hist_t [ENTRIES-1:0] tbl_q;
    logic  [IDX_W-1:0]   lk_idx;
    logic  [IDX_W-1:0]   res_idx;

    assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
    assign res_idx = res_pc[IDX_HI:IDX_LO];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        bht_entry u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd_en (res_valid && (res_idx == IDX_W'(i))),
            .taken  (res_taken),
            .state  (tbl_q[i])
        );
    end

    bht_lookup #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_lookup (
        .tbl     (tbl_q),
        .idx     (lk_idx),
        .pc      (lk_pc),
        .target  (lk_target),
        .taken   (pred_taken),
        .next_pc (pred_next_pc)
    );

    bht_resolve #(.PC_W(PC_W)) u_resolve (
        .cur        (tbl_q[res_idx]),
        .valid      (res_valid),
        .taken      (res_taken),
        .pc         (res_pc),
        .target     (res_target),
        .mispredict (mispredict),
        .recov_pc   (recov_pc)
    );
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PC_W-1:0]         lk_pc,
    input logic [PC_W-1:0]         lk_target,
    input logic                    pred_taken,
    input logic [PC_W-1:0]         pred_next_pc,
    input logic                    res_valid,
    input logic [PC_W-1:0]         res_pc,
    input logic [PC_W-1:0]         res_target,
    input logic                    res_taken,
    input logic                    mispredict,
    input logic [PC_W-1:0]         recov_pc,
    input logic [ENTRIES-1:0][1:0] tbl
);
    logic [IDX_W-1:0] ridx;
    logic [1:0]       cur;
    assign ridx = res_pc[IDX_W+1:2];
    assign cur  = tbl[ridx];

    AST_NEXT_PC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_next_pc == lk_target); // R6
    AST_NEXT_PC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == lk_pc + PC_W'(4)); // R6
    AST_NO_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !mispredict); // R7
    AST_RECOVER_PC: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> recov_pc == (res_taken ? res_target : res_pc + PC_W'(4))); // R8
    AST_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_taken |=>
        tbl[$past(ridx)] == (($past(cur) == 2'b00) ? 2'b00 : $past(cur) - 2'd1)); // R4
    AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_taken |=>
        tbl[$past(ridx)] == (($past(cur) == 2'b11) ? 2'b11 : $past(cur) + 2'd1)); // R5
    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(tbl)); // R9
endmodule

bind bht_predictor bht_predictor_chk #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .lk_target    (lk_target),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .res_valid    (res_valid),
    .res_pc       (res_pc),
    .res_target   (res_target),
    .res_taken    (res_taken),
    .mispredict   (mispredict),
    .recov_pc     (recov_pc),
    .tbl          (tbl_q)
);

// File: tb/bht_predictor_test.sv
`timescale 1ns/1ps
module bht_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0, lk_target = '0, res_pc = '0, res_target = '0;
    logic        res_valid = 1'b0, res_taken = 1'b0;
    logic        pred_taken, mispredict;
    logic [31:0] pred_next_pc, recov_pc;

    int checks = 0;
    int errors = 0;
    int model [64];

    always #2.5 clk = ~clk;

    bht_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_target(lk_target),
        .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_target(res_target),
        .res_taken(res_taken), .mispredict(mispredict), .recov_pc(recov_pc)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit rv, input logic [31:0] rpc, input bit rt,
                        input logic [31:0] rtg, input logic [31:0] lpc,
                        input logic [31:0] ltg, input string req);
        logic ep;
        logic [31:0] enp;
        int li;
        int ri;
        @(negedge clk);
        res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg;
        lk_pc = lpc; lk_target = ltg;
        #1;
        li = int'(lpc[7:2]);
        ri = int'(rpc[7:2]);
        ep = model[li] <= 1;
        enp = ep ? ltg : lpc + 32'd4;
        chk(pred_taken == ep, {req, " R3 pred_taken"}, 32'(pred_taken), 32'(ep));
        chk(pred_next_pc == enp, {req, " R6 pred_next_pc"}, pred_next_pc, enp);
        if (rv) begin
            chk(mispredict == ((model[ri] <= 1) != rt), {req, " R7 mispredict"},
                32'(mispredict), 32'((model[ri] <= 1) != rt));
            chk(recov_pc == (rt ? rtg : rpc + 32'd4), {req, " R8 recov_pc"},
                recov_pc, rt ? rtg : rpc + 32'd4);
            if (rt) model[ri] = (model[ri] == 0) ? 0 : model[ri] - 1;
            else    model[ri] = (model[ri] == 3) ? 3 : model[ri] + 1;
        end else begin
            chk(mispredict == 1'b0, {req, " R7 idle mispredict"}, 32'(mispredict), 0);
        end
    endtask

    function automatic logic [31:0] apc(input int idx, input int hi);
        return {hi[23:0], idx[5:0], 2'b00};
    endfunction

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2: every entry guesses not taken after reset
        for (int i = 0; i < 64; i++)
            step(0, 32'h0, 1'b1, 32'h0, apc(i, 7), 32'h4000_0000 + i, "R2 reset");

        // R4 R5: saturation on entry 5
        for (int k = 0; k < 6; k++)
            step(1, apc(5, 1), 1'b1, 32'h9000, apc(5, 1), 32'h9000, "R4 taken run");
        for (int k = 0; k < 6; k++)
            step(1, apc(5, 2), 1'b0, 32'h9000, apc(5, 3), 32'h9100, "R5 fall run");

        // R10: same-entry collision, lookup sees pre-update value (sweep)
        for (int i = 0; i < 64; i++)
            for (int k = 0; k < 8; k++)
                step(1, apc(i, k), ((i * 5 + k * 3) % 7) < 4, 32'h2000_0000 + 16 * k,
                     apc(i, k + 9), 32'h3000_0000 + i, "R10 collide");

        // R1: alias through upper bits, other entries untouched
        for (int i = 0; i < 64; i++)
            step(1, apc(i, 32'h1234), (i % 3) != 0, 32'h5000,
                 apc((i + 17) % 64, 32'h777), 32'h6000, "R1 alias");
        for (int i = 0; i < 64; i++)
            step(0, 32'h0, 1'b0, 32'h0, apc(i, 32'hABCDE), 32'h7000 + i, "R1 readback");

        // R9: invalid resolves change nothing
        for (int i = 0; i < 64; i++)
            step(0, apc(i, 3), i[0], 32'h8000, apc(i, 4), 32'h8100, "R9 idle");
        for (int i = 0; i < 64; i++)
            step(0, 32'h0, 1'b0, 32'h0, apc(i, 5), 32'h8200, "R9 readback");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule